// File: doc/BRIEF.md
# Dual-Width Register Bus Adapter

This block connects a synchronous, memory-style host bus to a bank of 16-bit registers. Part of the bank is held inside the adapter as read/write control words. The rest is a set of read-only status and counter words that other logic drives into the adapter. Chip select, read strobe, write strobe, address and write data are all sampled on the rising clock edge. Read data comes from a register and is valid in the cycle after the read strobe.

A static width input chooses how the host reaches the registers. When it is low, each access moves a whole 16-bit word. When it is high, each access moves one byte, and the top write-data line chooses which half of the addressed register is used. A low-byte read in byte mode also copies the upper half of the same register into a holding latch. The high-byte read that follows returns that copy, so a counter that carries from its low byte into its high byte between the two reads still gives a consistent 16-bit value.

Writes are fully decoded. A write reaches a control word only when the address falls inside the control range. Writes to status words and to unmapped addresses change nothing.

Top module: `regbus_bridge`

## Requirements
- R1: During and right after reset, `rdata` is 0 and every control word on `ctrl_q` is 0.
- R2: In word mode (`byte_mode`=0), a write to a control address (0 to N_CTRL-1) stores all 16 bits of `wdata`. A read returns the whole word on `rdata` one cycle after the read strobe.
- R3: In byte mode, the byte-select line is `wdata[15]` (0 = bits 7:0, 1 = bits 15:8) and the byte value is on `wdata[7:0]`. A write changes only the selected byte of the control word; the other byte keeps its value.
- R4: In byte mode, a low-byte read puts bits 7:0 of the addressed word on `rdata[7:0]`, and every byte-mode read drives `rdata[15:8]` to 0.
- R5: A low-byte read in byte mode of a mapped address copies bits 15:8 of that word into a snapshot latch. A high-byte read returns the latch on `rdata[7:0]`, even if the word has changed since the copy.
- R6: Only low-byte reads of mapped addresses load the snapshot latch. High-byte reads, word-mode reads and unmapped reads leave it unchanged.
- R7: Status words sit at addresses STAT_BASE to STAT_BASE+N_STAT-1. Reads return the live `stat_i` word, and writes to those addresses change no control word.
- R8: A write to an address that maps to no register changes no control word. The value read from such an address is unspecified.
- R9: When `cs` is low, strobes are ignored. `rdata` holds its value in every cycle without an accepted read.
- R10: When read and write strobes are both active in one cycle, the write takes effect and the read returns the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | Static width select: 1 = byte access, 0 = word access |
| cs | input | 1 | Chip select; gates both strobes |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data; bit 15 is the byte select in byte mode |
| rdata | output | 16 | Registered read data |
| ctrl_q | output | N_CTRL*16 | Control words, word i at bits 16*i+15:16*i |
| stat_i | input | N_STAT*16 | Status and counter words, word j at bits 16*j+15:16*j |

## Verification
Write results appear on `ctrl_q` at the same edge that samples the write strobe. Read results appear on `rdata` at the edge that samples the read strobe, so both are due one edge after the inputs are driven. The bench drives every access on a falling edge and samples one time unit after the next rising edge. It drops the strobes before the following edge, so each check sees exactly one accepted access. For the snapshot check, the status input changes between the two byte reads, which shows that the high-byte value comes from the earlier capture and not from the live word.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Decode class of an address
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CTRL = 2'd1,
    HIT_STAT = 2'd2
  } hit_e;

  // Per-access byte lane enables
  typedef struct packed {
    logic hi;
    logic lo;
  } lane_t;

endpackage

// File: rtl/regbus_decode.sv
module regbus_decode
  import regbus_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int N_CTRL    = 8,
  parameter int STAT_BASE = 16,
  parameter int N_STAT    = 8,
  localparam int CI_W     = (N_CTRL > 1) ? $clog2(N_CTRL) : 1,
  localparam int SI_W     = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              hit,
  output logic [CI_W-1:0]   ctrl_idx,
  output logic [SI_W-1:0]   stat_idx
);

  localparam logic [ADDR_W:0] CTRL_END  = (ADDR_W+1)'(N_CTRL);
  localparam logic [ADDR_W:0] STAT_LO   = (ADDR_W+1)'(STAT_BASE);
  localparam logic [ADDR_W:0] STAT_HI   = (ADDR_W+1)'(STAT_BASE + N_STAT);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] stat_off;
  logic            in_ctrl;
  logic            in_stat;

  always_comb begin
    addr_x   = {1'b0, addr};
    stat_off = addr_x - STAT_LO;
    in_ctrl  = (addr_x < CTRL_END);
    in_stat  = (addr_x >= STAT_LO) && (addr_x < STAT_HI);
    ctrl_idx = addr_x[CI_W-1:0];
    stat_idx = stat_off[SI_W-1:0];
    if (in_ctrl) begin
      hit = HIT_CTRL;
    end else if (in_stat) begin
      hit = HIT_STAT;
    end else begin
      hit = HIT_NONE;
    end
  end

endmodule

// File: rtl/regbus_ctrl_file.sv
module regbus_ctrl_file
  import regbus_pkg::*;
#(
  parameter int          N_CTRL    = 8,
  parameter logic [15:0] RESET_VAL = 16'h0000,
  localparam int         CI_W      = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [CI_W-1:0]          idx,
  input  lane_t                    lanes,
  input  logic [WORD_W-1:0]        wd,
  output logic [N_CTRL*WORD_W-1:0] ctrl_q
);

  logic [WORD_W-1:0] word_q [N_CTRL];
  logic [WORD_W-1:0] word_d [N_CTRL];
  logic              word_en [N_CTRL];

  for (genvar g = 0; g < N_CTRL; g++) begin : g_word
    // next-state
    always_comb begin
      word_en[g] = we && (idx == CI_W'(g));
      word_d[g]  = word_q[g];
      if (lanes.lo) begin
        word_d[g][BYTE_W-1:0] = wd[BYTE_W-1:0];
      end
      if (lanes.hi) begin
        word_d[g][WORD_W-1:BYTE_W] = wd[WORD_W-1:BYTE_W];
      end
    end

    // register
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= RESET_VAL;
      end else if (word_en[g]) begin
        word_q[g] <= word_d[g];
      end
    end

    assign ctrl_q[g*WORD_W +: WORD_W] = word_q[g];
  end

endmodule

// File: rtl/regbus_read_path.sv
module regbus_read_path
  import regbus_pkg::*;
#(
  parameter int  N_CTRL = 8,
  parameter int  N_STAT = 8,
  localparam int CI_W   = (N_CTRL > 1) ? $clog2(N_CTRL) : 1,
  localparam int SI_W   = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     byte_mode,
  input  logic                     byte_hi,
  input  hit_e                     hit,
  input  logic [CI_W-1:0]          ctrl_idx,
  input  logic [SI_W-1:0]          stat_idx,
  input  logic [N_CTRL*WORD_W-1:0] ctrl_q,
  input  logic [N_STAT*WORD_W-1:0] stat_i,
  output logic [WORD_W-1:0]        rdata
);

  logic [WORD_W-1:0] ctrl_w [N_CTRL];
  logic [WORD_W-1:0] stat_w [N_STAT];
  logic [WORD_W-1:0] sel_word;
  logic              mapped;
  logic              snap_en;
  logic [BYTE_W-1:0] snap_q;
  logic [BYTE_W-1:0] snap_d;
  logic [WORD_W-1:0] rdata_d;

  for (genvar c = 0; c < N_CTRL; c++) begin : g_cw
    assign ctrl_w[c] = ctrl_q[c*WORD_W +: WORD_W];
  end
  for (genvar s = 0; s < N_STAT; s++) begin : g_sw
    assign stat_w[s] = stat_i[s*WORD_W +: WORD_W];
  end

  // word selection
  always_comb begin
    unique case (hit)
      HIT_CTRL: sel_word = ctrl_w[ctrl_idx];
      HIT_STAT: sel_word = stat_w[stat_idx];
      default:  sel_word = '0;
    endcase
    mapped = (hit != HIT_NONE);
  end

  // snapshot and read-data next-state
  always_comb begin
    snap_en = rd_en && byte_mode && !byte_hi && mapped;
    snap_d  = sel_word[WORD_W-1:BYTE_W];
    if (!byte_mode) begin
      rdata_d = sel_word;
    end else if (byte_hi) begin
      rdata_d = {{BYTE_W{1'b0}}, snap_q};
    end else begin
      rdata_d = {{BYTE_W{1'b0}}, sel_word[BYTE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_en) begin
      snap_q <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge
  import regbus_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          N_CTRL    = 8,
  parameter int          STAT_BASE = 16,
  parameter int          N_STAT    = 8,
  parameter logic [15:0] RESET_VAL = 16'h0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_mode,
  input  logic                     cs,
  input  logic                     rd,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [15:0]              wdata,
  output logic [15:0]              rdata,
  output logic [N_CTRL*16-1:0]     ctrl_q,
  input  logic [N_STAT*16-1:0]     stat_i
);

  localparam int CI_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;
  localparam int SI_W = (N_STAT > 1) ? $clog2(N_STAT) : 1;

  hit_e              hit;
  logic [CI_W-1:0]   ctrl_idx;
  logic [SI_W-1:0]   stat_idx;
  logic              rd_en;
  logic              wr_en;
  logic              byte_hi;
  lane_t             lanes;
  logic [WORD_W-1:0] wd_steer;

  regbus_decode #(
    .ADDR_W   (ADDR_W),
    .N_CTRL   (N_CTRL),
    .STAT_BASE(STAT_BASE),
    .N_STAT   (N_STAT)
  ) u_decode (
    .addr    (addr),
    .hit     (hit),
    .ctrl_idx(ctrl_idx),
    .stat_idx(stat_idx)
  );

  // strobe qualification and byte steering
  always_comb begin
    rd_en   = cs && rd;
    wr_en   = cs && wr && (hit == HIT_CTRL);
    byte_hi = byte_mode && wdata[WORD_W-1];
    if (byte_mode) begin
      lanes.hi = byte_hi;
      lanes.lo = !byte_hi;
      wd_steer = {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
    end else begin
      lanes.hi = 1'b1;
      lanes.lo = 1'b1;
      wd_steer = wdata;
    end
  end

  regbus_ctrl_file #(
    .N_CTRL   (N_CTRL),
    .RESET_VAL(RESET_VAL)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .idx   (ctrl_idx),
    .lanes (lanes),
    .wd    (wd_steer),
    .ctrl_q(ctrl_q)
  );

  regbus_read_path #(
    .N_CTRL(N_CTRL),
    .N_STAT(N_STAT)
  ) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .byte_mode(byte_mode),
    .byte_hi  (byte_hi),
    .hit      (hit),
    .ctrl_idx (ctrl_idx),
    .stat_idx (stat_idx),
    .ctrl_q   (ctrl_q),
    .stat_i   (stat_i),
    .rdata    (rdata)
  );

endmodule

// File: rtl/regbus_bridge_chk.sv
module regbus_bridge_chk #(
  parameter int ADDR_W = 6,
  parameter int N_CTRL = 8,
  parameter int N_STAT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 byte_mode,
  input logic                 cs,
  input logic                 rd,
  input logic                 wr,
  input logic [ADDR_W-1:0]    addr,
  input logic [15:0]          wdata,
  input logic [15:0]          rdata,
  input logic [N_CTRL*16-1:0] ctrl_q,
  input logic [N_STAT*16-1:0] stat_i
);

  localparam logic [ADDR_W:0] CTRL_END = (ADDR_W+1)'(N_CTRL);

  logic [N_CTRL*8-1:0] hi_bytes;
  logic [N_CTRL*8-1:0] lo_bytes;
  logic                stat_seen;

  always_comb begin
    for (int i = 0; i < N_CTRL; i++) begin
      hi_bytes[i*8 +: 8] = ctrl_q[i*16+8 +: 8];
      lo_bytes[i*8 +: 8] = ctrl_q[i*16 +: 8];
    end
    stat_seen = ^stat_i;
  end

  // R1
  r1_reset_rdata_chk: assert property (@(posedge clk)
    !rst_n |=> (rdata == 16'h0000));

  // R9
  r9_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> $stable(rdata));

  // R9
  r9_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(ctrl_q));

  // R4
  r4_byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && byte_mode) |=> (rdata[15:8] == 8'h00));

  // R8
  r8_unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && ({1'b0, addr} >= CTRL_END)) |=> $stable(ctrl_q));

  // R3
  r3_lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && byte_mode && !wdata[15]) |=> $stable(hi_bytes));

  // R3
  r3_hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && byte_mode && wdata[15]) |=> $stable(lo_bytes));

  // R7
  r7_stat_input_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(stat_seen));

endmodule

bind regbus_bridge regbus_bridge_chk #(
  .ADDR_W(ADDR_W),
  .N_CTRL(N_CTRL),
  .N_STAT(N_STAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .byte_mode(byte_mode),
  .cs       (cs),
  .rd       (rd),
  .wr       (wr),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .ctrl_q   (ctrl_q),
  .stat_i   (stat_i)
);

// File: tb/regbus_bridge_tb.sv
`timescale 1ns/1ps
module regbus_bridge_tb;

  localparam int ADDR_W = 6;
  localparam int N_CTRL = 8;
  localparam int N_STAT = 8;

  logic                 clk;
  logic                 rst_n;
  logic                 byte_mode;
  logic                 cs;
  logic                 rd;
  logic                 wr;
  logic [ADDR_W-1:0]    addr;
  logic [15:0]          wdata;
  logic [15:0]          rdata;
  logic [N_CTRL*16-1:0] ctrl_q;
  logic [N_STAT*16-1:0] stat_i;
  logic [15:0]          counter;

  int checks   = 0;
  int failures = 0;
  logic done   = 1'b0;

  regbus_bridge #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .STAT_BASE(16), .N_STAT(N_STAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ctrl_q(ctrl_q), .stat_i(stat_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // status word 0 is a counter under bench control, others fixed 0x5000+j
  always_comb begin
    for (int j = 0; j < N_STAT; j++) stat_i[j*16 +: 16] = 16'h5000 + 16'(j);
    stat_i[15:0] = counter;
  end

  typedef struct packed {
    logic        bm;
    logic        rdx;
    logic        wrx;
    logic [5:0]  a;
    logic [15:0] wd;
    logic        chk;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 6'd1,  16'hA5C3, 1'b0, 16'h0000, 4'd2},  // R2 word write
    '{1'b0, 1'b1, 1'b0, 6'd1,  16'h0000, 1'b1, 16'hA5C3, 4'd2},  // R2 word read
    '{1'b0, 1'b0, 1'b1, 6'd2,  16'h1234, 1'b0, 16'h0000, 4'd3},
    '{1'b1, 1'b0, 1'b1, 6'd2,  16'h0099, 1'b0, 16'h0000, 4'd3},  // R3 low byte write
    '{1'b0, 1'b1, 1'b0, 6'd2,  16'h0000, 1'b1, 16'h1299, 4'd3},
    '{1'b1, 1'b0, 1'b1, 6'd2,  16'h8077, 1'b0, 16'h0000, 4'd3},  // R3 high byte write
    '{1'b0, 1'b1, 1'b0, 6'd2,  16'h0000, 1'b1, 16'h7799, 4'd3},
    '{1'b1, 1'b1, 1'b0, 6'd2,  16'h0000, 1'b1, 16'h0099, 4'd4},  // R4 low byte read
    '{1'b1, 1'b1, 1'b0, 6'd2,  16'h8000, 1'b1, 16'h0077, 4'd5},  // R5 high byte read
    '{1'b0, 1'b0, 1'b1, 6'd17, 16'hFFFF, 1'b0, 16'h0000, 4'd7},  // R7 write to status
    '{1'b0, 1'b1, 1'b0, 6'd17, 16'h0000, 1'b1, 16'h5001, 4'd7}   // R7 status read
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access: drive on falling edge, sample 1 ns after the rising edge, release strobes
  task automatic access(input logic bm, input logic c, input logic r, input logic w,
                        input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    byte_mode = bm; cs = c; rd = r; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N_CTRL*16-1:0] saved;
    rst_n = 1'b0; byte_mode = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0;
    addr = '0; wdata = '0; counter = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 rdata at reset", 128'(rdata), 128'h0);
    check("R1 ctrl at reset", 128'(ctrl_q), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 rdata after release", 128'(rdata), 128'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      access(VEC[v].bm, 1'b1, VEC[v].rdx, VEC[v].wrx, VEC[v].a, VEC[v].wd);
      if (VEC[v].chk)
        check($sformatf("R%0d vector %0d", VEC[v].req, v), 128'(rdata), 128'(VEC[v].exp));
    end
    // R7 write to status changed no control word
    check("R7 ctrl after status write", 128'(ctrl_q[47:0]), 128'h7799_A5C3_0000);

    // R5 counter carry between byte reads
    counter = 16'h12FF;
    access(1'b1, 1'b1, 1'b1, 1'b0, 6'd16, 16'h0000);
    check("R5 counter low byte", 128'(rdata), 128'h00FF);
    counter = 16'h1300;
    access(1'b1, 1'b1, 1'b1, 1'b0, 6'd16, 16'h8000);
    check("R5 counter high byte snapshot", 128'(rdata), 128'h0012);
    access(1'b0, 1'b1, 1'b1, 1'b0, 6'd16, 16'h0000);
    check("R7 live status word", 128'(rdata), 128'h1300);

    // R6 latch untouched by high, word and unmapped reads
    counter = 16'h4400;
    access(1'b1, 1'b1, 1'b1, 1'b0, 6'd16, 16'h8000);
    check("R6 high read no reload", 128'(rdata), 128'h0012);
    access(1'b0, 1'b1, 1'b1, 1'b0, 6'd16, 16'h0000);
    access(1'b1, 1'b1, 1'b1, 1'b0, 6'd40, 16'h0000);
    access(1'b1, 1'b1, 1'b1, 1'b0, 6'd16, 16'h8000);
    check("R6 word and unmapped reads no reload", 128'(rdata), 128'h0012);

    // R8 unmapped writes
    saved = ctrl_q;
    access(1'b0, 1'b1, 1'b0, 1'b1, 6'd40, 16'hFFFF);
    access(1'b0, 1'b1, 1'b0, 1'b1, 6'd12, 16'hFFFF);
    access(1'b1, 1'b1, 1'b0, 1'b1, 6'd63, 16'h80FF);
    check("R8 unmapped writes", 128'(ctrl_q), 128'(saved));

    // R9 chip select low
    access(1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 16'h0F0F);
    check("R9 write without cs", 128'(ctrl_q), 128'(saved));
    access(1'b0, 1'b1, 1'b1, 1'b0, 6'd2, 16'h0000);
    access(1'b0, 1'b0, 1'b1, 1'b0, 6'd1, 16'h0000);
    check("R9 read without cs holds rdata", 128'(rdata), 128'h7799);
    repeat (3) @(posedge clk);
    #1;
    check("R9 idle holds rdata", 128'(rdata), 128'h7799);

    // R10 read and write together
    access(1'b0, 1'b1, 1'b1, 1'b1, 6'd3, 16'hBEEF);
    check("R10 read returns old word", 128'(rdata), 128'h0000);
    access(1'b0, 1'b1, 1'b1, 1'b0, 6'd3, 16'h0000);
    check("R10 write took effect", 128'(rdata), 128'hBEEF);

    // R2 last control word, full width
    access(1'b0, 1'b1, 1'b0, 1'b1, 6'd7, 16'hFFFF);
    check("R2 top control word", 128'(ctrl_q[127:112]), 128'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule